// File: doc/BRIEF.md
# AHB Subordinate-Port Cycle Activity Monitor

This block watches the transfer-type, select and ready lines at the port of a single AHB subordinate. It never drives the bus. On each clock it sorts the cycle into exactly one of five categories. A cycle is productive when a real transfer completes to this subordinate. Otherwise it is idle (the master has nothing to do), a master pause (the burst is held), a subordinate wait (the transfer is in flight but not completing), or not-selected (the bus is serving another subordinate). Each category has its own saturating counter. A total-cycle counter runs alongside them. All of these count only while a measurement window is open. Start, stop and clear pulses from the controlling logic open, close and zero the window.

Throughput for a window is the productive count divided by the total count. The other four counters account for every lost cycle and give the reason for each. The monitor also sends out a same-cycle pulse on each productive cycle, which nearby logic can use as an access enable. It raises a sticky error flag if the subordinate reports that it acted on a cycle that carried no work. All counters are read combinationally through a small index-and-data register port.

Top module: `bus_activity_monitor`

## Requirements
- R1: A cycle is productive only when the transfer type is NONSEQ (2'b10) or SEQ (2'b11), the select line is high and the ready line is high, all in the same cycle. `work_pulse` is high in exactly those cycles, whether or not the window is open. Each productive cycle inside the window adds one to the productive counter.
- R2: A cycle with transfer type IDLE (2'b00) adds to the idle counter, whatever the select and ready lines are.
- R3: A cycle with transfer type BUSY (2'b01) adds to the master-pause counter, whatever the select and ready lines are.
- R4: A cycle with a real transfer type, select high and ready low adds to the subordinate-wait counter.
- R5: A cycle with a real transfer type and select low adds to the not-selected counter, whatever the ready line is. Not-selected takes priority over wait.
- R6: Each cycle inside the window adds to the total counter and to exactly one category counter. While nothing is saturated, the four non-productive counters together equal total minus productive.
- R7: A start pulse opens the window from the next cycle on. A stop pulse closes it after the cycle in which it arrives, and that cycle is still counted. When start and stop come together, stop wins. While the window is closed, no counter changes.
- R8: A clear pulse zeroes every counter and the phantom flag at the next edge, including any count due in that cycle. Clear overrides start and stop, and it leaves the window state unchanged.
- R9: Each counter is `CNT_W` bits wide (default 32). It stops at all-ones and does not wrap.
- R10: If `sub_access` is high in any cycle that is not productive, `phantom_err` goes high at the next edge. It stays high until a clear pulse or reset. `sub_access` on a productive cycle does not raise it.
- R11: `rd_data` shows a counter chosen by `rd_sel` in the same cycle: 0 total, 1 productive, 2 idle, 3 master-pause, 4 subordinate-wait, 5 not-selected. Any other index reads zero.
- R12: Reset is synchronous and active-low. After reset the window is closed, every counter is zero and the phantom flag is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trans_type | input | 2 | Transfer type seen at the subordinate port |
| slave_sel | input | 1 | Select line for this subordinate |
| bus_ready | input | 1 | Bus ready line (low during wait states) |
| sub_access | input | 1 | Subordinate reports it performed an access this cycle |
| win_start | input | 1 | Open the measurement window |
| win_stop | input | 1 | Close the measurement window |
| win_clear | input | 1 | Zero all counters and the phantom flag |
| rd_sel | input | 3 | Counter index for readback |
| rd_data | output | CNT_W | Selected counter value |
| work_pulse | output | 1 | High during each productive cycle |
| window_active | output | 1 | Measurement window is open |
| phantom_err | output | 1 | Sticky flag: access reported on a non-productive cycle |

## Verification
Some properties are checked on every cycle. A productive cycle inside the window advances the productive counter by exactly one. The category counters add up to the total while it is unsaturated. A saturated counter holds. Clear zeroes a counter at the next edge, and a counter without an increment stays put. Stop and start set the window state as R7 and R8 require. The phantom flag sets on a non-productive access and then stays set. Other behaviour only the directed scenarios can show: that each mix of transfer type, select and ready reaches the right counter through the priority order, that the stop cycle itself is counted, that clear takes precedence over start and stop, that saturation holds over a long run, and that the readback index map, including the unused indices, is correct.

// File: rtl/bam_pkg.sv
// Package: shared encodings for the bus activity monitor.
// Assumes transfer-type codes follow the AHB two-bit encoding.
package bam_pkg;
    typedef enum logic [1:0] {
        TR_IDLE   = 2'b00,
        TR_BUSY   = 2'b01,
        TR_NONSEQ = 2'b10,
        TR_SEQ    = 2'b11
    } trans_e;

    // Category positions; readback index is position + 1 (index 0 is total)
    localparam int CAT_WORK  = 0;
    localparam int CAT_IDLE  = 1;
    localparam int CAT_PAUSE = 2;
    localparam int CAT_WAIT  = 3;
    localparam int CAT_UNSEL = 4;
    localparam int NUM_CAT   = 5;
endpackage

// File: rtl/activity_classifier.sv
// Module: activity_classifier
// Sorts each bus cycle into exactly one category, one-hot, using a fixed
// priority: idle, pause, not-selected, wait, productive.
// Assumes inputs are already synchronous to the bus clock.
module activity_classifier
    import bam_pkg::*;
(
    input  logic [1:0]         trans,
    input  logic               sel,
    input  logic               ready,
    output logic [NUM_CAT-1:0] cat_vec,
    output logic               work
);
    // Priority decode of the current cycle into a one-hot category
    always_comb begin
        cat_vec = '0;
        if (trans == TR_IDLE) begin
            cat_vec[CAT_IDLE] = 1'b1;
        end else if (trans == TR_BUSY) begin
            cat_vec[CAT_PAUSE] = 1'b1;
        end else if (!sel) begin
            cat_vec[CAT_UNSEL] = 1'b1;
        end else if (!ready) begin
            cat_vec[CAT_WAIT] = 1'b1;
        end else begin
            cat_vec[CAT_WORK] = 1'b1;
        end
    end

    // Productive flag taken from the decoded category
    always_comb work = cat_vec[CAT_WORK];
endmodule

// File: rtl/window_ctrl.sv
// Module: window_ctrl
// Holds the measurement-window state. Clear freezes the state, stop beats
// start. Assumes start/stop/clear are single-cycle pulses from control logic.
module window_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic stop,
    input  logic clear,
    output logic active
);
    // Window state update with clear > stop > start priority
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
        end else if (!clear) begin
            if (stop) begin
                active <= 1'b0;
            end else if (start) begin
                active <= 1'b1;
            end
        end
    end

    a_r7_stop_closes: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(stop) && !$past(clear)) |-> !active);
    a_r7_start_opens: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(start) && !$past(stop) && !$past(clear)) |-> active);
    a_r8_clear_keeps_window: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clear) |-> (active == $past(active)));
endmodule

// File: rtl/sat_counter.sv
// Module: sat_counter
// Counter of width W that zeroes on clear and stops at all-ones.
// Assumes clear has priority over increment.
module sat_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] q
);
    localparam logic [W-1:0] MAXV = '1;

    // Count up until saturation; clear wins
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (clr) begin
            q <= '0;
        end else if (inc && (q != MAXV)) begin
            q <= q + 1'b1;
        end
    end

    a_r9_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(q) == MAXV && !$past(clr)) |-> (q == MAXV));
    a_r8_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clr) |-> (q == '0));
    a_r7_hold_no_inc: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(inc) && !$past(clr)) |-> (q == $past(q)));
endmodule

// File: rtl/phantom_check.sv
// Module: phantom_check
// Sticky flag for a subordinate that reports an access on a cycle that
// carried no work. Assumes work is the same-cycle productive indication.
module phantom_check (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic access,
    input  logic work,
    output logic flag
);
    // Set on a non-work access, hold until clear or reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (clear) begin
            flag <= 1'b0;
        end else if (access && !work) begin
            flag <= 1'b1;
        end
    end

    a_r10_sets: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(access) && !$past(work) && !$past(clear)) |-> flag);
    a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(flag) && !$past(clear)) |-> flag);
endmodule

// File: rtl/bus_activity_monitor.sv
// Module: bus_activity_monitor (top)
// Passive cycle classifier and counter bank for one AHB subordinate port.
// Assumes all inputs are sampled on the bus clock; it drives nothing on the bus.
module bus_activity_monitor
    import bam_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       trans_type,
    input  logic             slave_sel,
    input  logic             bus_ready,
    input  logic             sub_access,
    input  logic             win_start,
    input  logic             win_stop,
    input  logic             win_clear,
    input  logic [SEL_W-1:0] rd_sel,
    output logic [CNT_W-1:0] rd_data,
    output logic             work_pulse,
    output logic             window_active,
    output logic             phantom_err
);
    localparam int SUM_W = CNT_W + 3;
    localparam logic [CNT_W-1:0] CMAX = '1;

    logic [NUM_CAT-1:0] cat_vec;
    logic               work;
    logic               active;
    logic [CNT_W-1:0]   total_cnt;
    logic [CNT_W-1:0]   cat_cnt [NUM_CAT];
    logic [SUM_W-1:0]   cat_sum;

    activity_classifier u_cls (
        .trans   (trans_type),
        .sel     (slave_sel),
        .ready   (bus_ready),
        .cat_vec (cat_vec),
        .work    (work)
    );

    window_ctrl u_win (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (win_start),
        .stop   (win_stop),
        .clear  (win_clear),
        .active (active)
    );

    sat_counter #(.W(CNT_W)) u_total (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (win_clear),
        .inc   (active),
        .q     (total_cnt)
    );

    for (genvar g = 0; g < NUM_CAT; g++) begin : g_cat
        sat_counter #(.W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (win_clear),
            .inc   (active && cat_vec[g]),
            .q     (cat_cnt[g])
        );
    end

    phantom_check u_ph (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (win_clear),
        .access (sub_access),
        .work   (work),
        .flag   (phantom_err)
    );

    // Readback mux: index 0 is total, 1..NUM_CAT are categories
    always_comb begin
        rd_data = '0;
        if (rd_sel == '0) begin
            rd_data = total_cnt;
        end
        for (int k = 0; k < NUM_CAT; k++) begin
            if (int'(rd_sel) == k + 1) begin
                rd_data = cat_cnt[k];
            end
        end
    end

    // Drive status outputs
    always_comb begin
        work_pulse    = work;
        window_active = active;
    end

    // Sum of category counters, used by the accounting check
    always_comb begin
        cat_sum = '0;
        for (int k = 0; k < NUM_CAT; k++) begin
            cat_sum = cat_sum + SUM_W'(cat_cnt[k]);
        end
    end

    a_r6_sum_matches: assert property (@(posedge clk) disable iff (!rst_n)
        (total_cnt != CMAX) |-> (cat_sum == SUM_W'(total_cnt)));
    a_r1_work_counted: assert property (@(posedge clk) disable iff (!rst_n)
        (active && work_pulse && !win_clear && cat_cnt[CAT_WORK] != CMAX)
        |=> (cat_cnt[CAT_WORK] == $past(cat_cnt[CAT_WORK]) + 1'b1));
endmodule

// File: tb/sim_bus_activity_monitor.sv
`timescale 1ns/1ps
module sim_bus_activity_monitor;
    localparam int CW   = 8;
    localparam int CMAX = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    trans_type = 2'b00;
    logic          slave_sel = 1'b0;
    logic          bus_ready = 1'b1;
    logic          sub_access = 1'b0;
    logic          win_start = 1'b0;
    logic          win_stop = 1'b0;
    logic          win_clear = 1'b0;
    logic [2:0]    rd_sel = 3'd0;
    logic [CW-1:0] rd_data;
    logic          work_pulse;
    logic          window_active;
    logic          phantom_err;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // expected model: index 0 total, 1 work, 2 idle, 3 pause, 4 wait, 5 unsel
    int e_cnt [6];
    bit e_active = 0;
    bit e_flag = 0;

    bus_activity_monitor #(.CNT_W(CW), .SEL_W(3)) u0 (
        .clk(clk), .rst_n(rst_n), .trans_type(trans_type), .slave_sel(slave_sel),
        .bus_ready(bus_ready), .sub_access(sub_access), .win_start(win_start),
        .win_stop(win_stop), .win_clear(win_clear), .rd_sel(rd_sel),
        .rd_data(rd_data), .work_pulse(work_pulse), .window_active(window_active),
        .phantom_err(phantom_err)
    );

    always #4 clk = ~clk;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Category by the requirement text; returns model index 1..5
    function automatic int cat_of(input logic [1:0] tr, input logic s, input logic r);
        if (tr == 2'b00) return 2;      // R2 idle
        if (tr == 2'b01) return 3;      // R3 pause
        if (!s) return 5;               // R5 not-selected
        if (!r) return 4;               // R4 wait
        return 1;                       // R1 productive
    endfunction

    // One bus cycle: drive at negedge, check pulse, update model at posedge
    task automatic cyc(input logic [1:0] tr, input logic s, input logic r,
                       input logic acc, input logic st, input logic sp, input logic cl);
        int c;
        @(negedge clk);
        trans_type = tr; slave_sel = s; bus_ready = r; sub_access = acc;
        win_start = st; win_stop = sp; win_clear = cl;
        c = cat_of(tr, s, r);
        #1;
        chk("R1", "work_pulse", int'(work_pulse), (c == 1) ? 1 : 0);
        @(posedge clk);
        if (e_active) begin
            if (e_cnt[0] < CMAX) e_cnt[0]++;
            if (e_cnt[c] < CMAX) e_cnt[c]++;
        end
        if (acc && c != 1) e_flag = 1;
        if (cl) begin
            for (int k = 0; k < 6; k++) e_cnt[k] = 0;
            e_flag = 0;
        end else if (sp) begin
            e_active = 0;
        end else if (st) begin
            e_active = 1;
        end
        #1;
        win_start = 0; win_stop = 0; win_clear = 0; sub_access = 0;
    endtask

    // Read all counters and status just after an edge, before the next negedge
    task automatic check_all(input string tag);
        string nm [6];
        string rq [6];
        nm[0] = "total"; nm[1] = "productive"; nm[2] = "idle";
        nm[3] = "pause"; nm[4] = "wait"; nm[5] = "unselected";
        rq[0] = "R6"; rq[1] = "R1"; rq[2] = "R2"; rq[3] = "R3"; rq[4] = "R4"; rq[5] = "R5";
        for (int k = 0; k < 6; k++) begin
            rd_sel = 3'(k);
            #0.4;
            chk({rq[k], "/", tag}, nm[k], int'(rd_data), e_cnt[k]);
        end
        chk({"R7/", tag}, "window_active", int'(window_active), int'(e_active));
        chk({"R10/", tag}, "phantom_err", int'(phantom_err), int'(e_flag));
    endtask

    task automatic t_reset();
        for (int k = 0; k < 6; k++) e_cnt[k] = 0;
        repeat (3) @(posedge clk);
        #1;
        check_all("R12");
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_classify();
        cyc(2'b00, 0, 1, 0, 0, 0, 1);   // clear
        cyc(2'b00, 0, 1, 0, 1, 0, 0);   // start, not counted
        cyc(2'b10, 1, 1, 0, 0, 0, 0);   // productive
        cyc(2'b11, 1, 1, 0, 0, 0, 0);   // productive
        cyc(2'b00, 1, 1, 0, 0, 0, 0);   // idle with select and ready
        cyc(2'b00, 0, 0, 0, 0, 0, 0);   // idle
        cyc(2'b01, 1, 1, 0, 0, 0, 0);   // pause
        cyc(2'b01, 1, 0, 0, 0, 0, 0);   // pause with ready low
        cyc(2'b10, 1, 0, 0, 0, 0, 0);   // wait
        cyc(2'b11, 1, 0, 0, 0, 0, 0);   // wait
        cyc(2'b10, 0, 1, 0, 0, 0, 0);   // unselected
        cyc(2'b11, 0, 0, 0, 0, 0, 0);   // unselected beats wait (R5)
        cyc(2'b11, 1, 1, 0, 0, 1, 0);   // productive on stop cycle, counted (R7)
        check_all("classify");
        chk("R1", "productive count", e_cnt[1], 3);
        chk("R5", "unselected count", e_cnt[5], 2);
        chk("R6", "total count", e_cnt[0], 11);
    endtask

    task automatic t_outside();
        cyc(2'b10, 1, 1, 0, 0, 0, 0);   // window closed: no counting (R7)
        cyc(2'b00, 1, 1, 0, 0, 0, 0);
        cyc(2'b10, 1, 0, 0, 0, 0, 0);
        check_all("R7-closed");
        cyc(2'b00, 0, 1, 0, 1, 1, 0);   // start and stop together: stays closed
        check_all("R7-both");
        cyc(2'b10, 1, 1, 0, 0, 0, 0);
        check_all("R7-both-hold");
    endtask

    task automatic t_clear();
        cyc(2'b00, 0, 1, 0, 1, 0, 0);   // open
        cyc(2'b10, 1, 1, 0, 0, 0, 0);
        cyc(2'b01, 1, 1, 0, 0, 0, 0);
        check_all("R8-pre");
        cyc(2'b10, 1, 1, 0, 0, 1, 1);   // clear with stop while open: window stays open
        check_all("R8-clear");
        cyc(2'b11, 1, 1, 0, 0, 0, 0);   // still counting after clear
        check_all("R8-after");
        cyc(2'b00, 0, 1, 0, 0, 1, 0);   // close
    endtask

    task automatic t_phantom();
        cyc(2'b00, 0, 1, 0, 0, 0, 1);
        cyc(2'b10, 1, 1, 1, 0, 0, 0);   // access on productive: no flag
        check_all("R10-ok");
        cyc(2'b10, 1, 0, 1, 0, 0, 0);   // access during wait: flag
        check_all("R10-set");
        cyc(2'b00, 0, 1, 0, 0, 0, 0);
        cyc(2'b10, 1, 1, 0, 0, 0, 0);
        check_all("R10-sticky");
        cyc(2'b01, 1, 1, 1, 0, 0, 1);   // clear beats a same-cycle phantom (R8)
        check_all("R8-flag");
    endtask

    task automatic t_readmap();
        for (int k = 6; k < 8; k++) begin
            rd_sel = 3'(k);
            #0.4;
            chk("R11", "unmapped index", int'(rd_data), 0);
        end
    endtask

    task automatic t_saturate();
        cyc(2'b00, 0, 1, 0, 1, 0, 1);   // clear; start is overridden
        cyc(2'b00, 0, 1, 0, 1, 0, 0);
        for (int i = 0; i < 300; i++) cyc(2'b11, 1, 1, 0, 0, 0, 0);
        cyc(2'b01, 1, 1, 0, 0, 1, 0);
        check_all("R9");
        chk("R9", "productive saturated", e_cnt[1], CMAX);
    endtask

    initial begin
        t_reset();
        t_classify();
        t_readmap();
        t_outside();
        t_clear();
        t_phantom();
        t_saturate();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        #1000000;
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule